// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block merges five interrupt sources into one vectored request for a CPU core. The sources are two active-low external pins, two timer overflow pulses and a serial-port request line. Software-held configuration inputs provide a master enable, a mask bit per source, a level-select bit per source and, for each external pin, a choice between level and falling-edge triggering. The core sees `irq_req` together with the handler address on `irq_vec` and the level of the winning request on `irq_hi`.

The core pulses `cpu_ack` when it vectors. The controller then marks the granted level as in service and clears the latched request of the granted source. A `cpu_reti` pulse ends the innermost active handler. The two in-service flags are exported and decide nesting. A handler at the upper level blocks every request. A handler at the lower level can only be preempted by an upper-level request. External pins are sampled once per 12-clock machine cycle. Instruction fetch and stack handling are left to the core.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source indices are ext0=0, timer0=1, ext1=2, timer1=3, serial=4. Source i is served at vector 0x03 + 8*i, giving 0x03, 0x0B, 0x13, 0x1B and 0x23. `irq_vec` reads 0x00 while `irq_req` is low.
- R2: When several enabled requests of the same level are pending, the one with the lowest index is presented.
- R3: A pending upper-level request (`cfg_hi` bit set) is presented ahead of any lower-level request, whatever its index.
- R4: While `busy_hi` is set, `irq_req` stays low. While only `busy_lo` is set, only upper-level requests may raise `irq_req`.
- R5: External pins are sampled once every 12 clocks, and only the sampled value affects the outputs. In level mode (`cfg_edge` bit 0) an external source requests for as long as its last sample is low.
- R6: With `cfg_gen` low no request is presented. A source whose `cfg_en` bit is low is never presented, but a latched request survives the masking.
- R7: `cpu_ack` while `irq_req` is high sets the in-service flag of the presented level one clock later. `cpu_ack` with `irq_req` low has no effect.
- R8: `cpu_reti` clears `busy_hi` if it is set, otherwise it clears `busy_lo`, one clock later.
- R9: In edge mode (`cfg_edge` bit 1) a high sample followed by a low sample latches a request. The latch stays set while the pin stays low and is cleared only when that source is acknowledged. An edge request held for 12 clocks high and then 12 clocks low is always seen.
- R10: A one-clock timer overflow pulse latches a request until that timer is acknowledged. The serial request is a level and is not cleared by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_gen | input | 1 | Master enable |
| cfg_en | input | 5 | Per-source enable, by source index |
| cfg_hi | input | 5 | Per-source upper-level select |
| cfg_edge | input | 2 | External pin trigger: 1 = falling edge, 0 = low level |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial port request level |
| cpu_ack | input | 1 | Core accepts the presented vector |
| cpu_reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request to the core |
| irq_hi | output | 1 | Presented request is upper level |
| irq_vec | output | 8 | Handler address |
| busy_hi | output | 1 | Upper-level handler in service |
| busy_lo | output | 1 | Lower-level handler in service |

## Verification
Timer, serial, enable and level-select changes reach `irq_req`, `irq_vec` and `irq_hi` through combinational logic from one flop, so the bench samples them on the falling edge right after the stimulus clock. Acknowledge and return effects appear one clock later, and the bench checks them at the next falling edge. A pin change waits for the next sampling tick, up to 12 clocks, so the bench waits 26 clocks after each pin change. For the sampling-period check it first finds the tick phase by polling for the first rising `irq_req`. It then expects the released pin to drop the request exactly 12 clocks later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 2;
  localparam int NSRC    = NUM_EXT + NUM_TMR + 1;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int SRC_SER = NSRC - 1;
  localparam int VEC_W   = 8;

  typedef struct packed {
    logic             req;
    logic             hi;
    logic [IDX_W-1:0] idx;
  } grant_t;

  // external pins and timers interleave in the index order
  function automatic int ext_slot(input int k);
    return 2 * k;
  endfunction

  function automatic int tmr_slot(input int k);
    return 2 * k + 1;
  endfunction

  // lowest set index wins
  function automatic logic [IDX_W-1:0] pick_first(input logic [NSRC-1:0] m);
    logic [IDX_W-1:0] p;
    p = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (m[i]) p = IDX_W'(i);
    return p;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx,
                                              input int base, input int stride);
    return VEC_W'(base + stride * int'(idx));
  endfunction
endpackage

// File: rtl/irq_mc_timer.sv
module irq_mc_timer #(
  parameter int MC_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(MC_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] edge_mode,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] req,
  output logic [NPIN-1:0] fall_seen
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic samp_q;
    logic flag_q;

    assign fall_seen[g] = tick & samp_q & ~pin_n[g] & edge_mode[g];
    assign req[g]       = edge_mode[g] ? flag_q : ~samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_q <= 1'b1;
        flag_q <= 1'b0;
      end else begin
        if (tick) samp_q <= pin_n[g];
        if (fall_seen[g])  flag_q <= 1'b1;
        else if (clr[g])   flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  hi_sel,
  input  logic             gen,
  input  logic             busy_hi,
  input  logic             busy_lo,
  output grant_t           grant,
  output logic [VEC_W-1:0] vec
);
  logic [NSRC-1:0] eligible;
  logic [NSRC-1:0] hi_cand;
  logic [NSRC-1:0] lo_cand;

  assign eligible = pend & en & {NSRC{gen}};
  assign hi_cand  = eligible & hi_sel;
  assign lo_cand  = eligible & ~hi_sel;

  always_comb begin
    grant = '0;
    if (!busy_hi) begin
      if (|hi_cand) begin
        grant.req = 1'b1;
        grant.hi  = 1'b1;
        grant.idx = pick_first(hi_cand);
      end else if (!busy_lo && |lo_cand) begin
        grant.req = 1'b1;
        grant.idx = pick_first(lo_cand);
      end
    end
  end

  assign vec = grant.req ? vec_of(grant.idx, VEC_BASE, VEC_STRIDE) : '0;
endmodule

// File: rtl/irq_service_tracker.sv
module irq_service_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic busy_hi,
  output logic busy_lo
);
  logic nxt_hi;
  logic nxt_lo;

  always_comb begin
    nxt_hi = busy_hi;
    nxt_lo = busy_lo;
    if (reti) begin
      if (busy_hi) nxt_hi = 1'b0;
      else         nxt_lo = 1'b0;
    end
    if (take) begin
      if (take_hi) nxt_hi = 1'b1;
      else         nxt_lo = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_hi <= 1'b0;
      busy_lo <= 1'b0;
    end else begin
      busy_hi <= nxt_hi;
      busy_lo <= nxt_lo;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int MC_CLKS    = 12,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_gen,
  input  logic [NSRC-1:0]     cfg_en,
  input  logic [NSRC-1:0]     cfg_hi,
  input  logic [NUM_EXT-1:0]  cfg_edge,
  input  logic [NUM_EXT-1:0]  ext_pin_n,
  input  logic [NUM_TMR-1:0]  tmr_ovf,
  input  logic                ser_req,
  input  logic                cpu_ack,
  input  logic                cpu_reti,
  output logic                irq_req,
  output logic                irq_hi,
  output logic [VEC_W-1:0]    irq_vec,
  output logic                busy_hi,
  output logic                busy_lo
);
  logic                tick;
  logic [NSRC-1:0]     pend;
  logic [NSRC-1:0]     clr;
  logic [NUM_EXT-1:0]  ext_req;
  logic [NUM_EXT-1:0]  ext_clr;
  logic [NUM_EXT-1:0]  ext_fall;
  logic [NUM_TMR-1:0]  tmr_flag_q;
  grant_t              grant;
  logic                take;

  irq_mc_timer #(.MC_CLKS(MC_CLKS)) u_mc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  irq_pin_sampler #(.NPIN(NUM_EXT)) u_pins (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pin_n(ext_pin_n), .edge_mode(cfg_edge), .clr(ext_clr),
    .req(ext_req), .fall_seen(ext_fall)
  );

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    assign pend[ext_slot(k)] = ext_req[k];
    assign ext_clr[k]        = clr[ext_slot(k)];
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    assign pend[tmr_slot(k)] = tmr_flag_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   tmr_flag_q[k] <= 1'b0;
      else if (tmr_ovf[k])          tmr_flag_q[k] <= 1'b1;
      else if (clr[tmr_slot(k)])    tmr_flag_q[k] <= 1'b0;
    end
  end

  assign pend[SRC_SER] = ser_req;

  irq_arbiter #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .pend(pend), .en(cfg_en), .hi_sel(cfg_hi), .gen(cfg_gen),
    .busy_hi(busy_hi), .busy_lo(busy_lo), .grant(grant), .vec(irq_vec)
  );

  assign take    = cpu_ack & grant.req;
  assign clr     = take ? (NSRC'(1) << grant.idx) : '0;
  assign irq_req = grant.req;
  assign irq_hi  = grant.hi;

  irq_service_tracker u_isr (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(grant.hi),
    .reti(cpu_reti), .busy_hi(busy_hi), .busy_lo(busy_lo)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int MC_CLKS = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cfg_gen,
  input logic       irq_req,
  input logic       irq_hi,
  input logic [7:0] irq_vec,
  input logic       busy_hi,
  input logic       busy_lo,
  input logic       cpu_ack,
  input logic       cpu_reti
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tick) |-> (gap_q == 16'(MC_CLKS - 1))); // R5
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 8'h23)); // R1
  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hi |-> !irq_req); // R4
  AST_LO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_lo && irq_req) |-> irq_hi); // R4
  AST_GEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_gen |-> !irq_req); // R6
  AST_ACK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && irq_hi) |=> busy_hi); // R7
  AST_ACK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && !irq_hi) |=> busy_lo); // R7
  AST_RETI_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && busy_hi) |=> !busy_hi); // R8
  AST_RETI_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && !busy_hi && busy_lo) |=> !busy_lo); // R8
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.MC_CLKS(MC_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_gen(cfg_gen),
  .irq_req(irq_req), .irq_hi(irq_hi), .irq_vec(irq_vec),
  .busy_hi(busy_hi), .busy_lo(busy_lo),
  .cpu_ack(cpu_ack), .cpu_reti(cpu_reti)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PIN_WAIT   = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_gen = 1'b1;
  logic [4:0] cfg_en = 5'h1F;
  logic [4:0] cfg_hi = 5'h00;
  logic [1:0] cfg_edge = 2'b00;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] tmr_ovf = 2'b00;
  logic       ser_req = 1'b0;
  logic       cpu_ack = 1'b0;
  logic       cpu_reti = 1'b0;
  logic       irq_req, irq_hi, busy_hi, busy_lo;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_gen(cfg_gen), .cfg_en(cfg_en),
    .cfg_hi(cfg_hi), .cfg_edge(cfg_edge), .ext_pin_n(ext_pin_n),
    .tmr_ovf(tmr_ovf), .ser_req(ser_req), .cpu_ack(cpu_ack),
    .cpu_reti(cpu_reti), .irq_req(irq_req), .irq_hi(irq_hi),
    .irq_vec(irq_vec), .busy_hi(busy_hi), .busy_lo(busy_lo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tmr(input int k);
    tmr_ovf[k] = 1'b1;
    wait_clk(1);
    tmr_ovf[k] = 1'b0;
  endtask

  task automatic do_ack();
    cpu_ack = 1'b1;
    wait_clk(1);
    cpu_ack = 1'b0;
  endtask

  task automatic do_reti();
    cpu_reti = 1'b1;
    wait_clk(1);
    cpu_reti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset irq_req", int'(irq_req), 0);
    chk("R7 reset busy_hi", int'(busy_hi), 0);
    chk("R8 reset busy_lo", int'(busy_lo), 0);
    chk("R1 idle vector", int'(irq_vec), 8'h00);
  endtask

  task automatic t_timer_vec();
    do_ack();
    chk("R7 ack without request ignored", int'(busy_lo | busy_hi), 0);
    pulse_tmr(0);
    chk("R10 timer0 latched", int'(irq_req), 1);
    chk("R1 timer0 vector", int'(irq_vec), 8'h0B);
    do_ack();
    chk("R7 ack sets busy_lo", int'(busy_lo), 1);
    chk("R10 timer0 cleared by ack", int'(irq_req), 0);
    do_reti();
    chk("R8 reti clears busy_lo", int'(busy_lo), 0);
    chk("R10 no request after reti", int'(irq_req), 0);
  endtask

  task automatic t_serial();
    ser_req = 1'b1;
    wait_clk(1);
    chk("R1 serial vector", int'(irq_vec), 8'h23);
    do_ack();
    chk("R4 low handler masks low request", int'(irq_req), 0);
    do_reti();
    chk("R10 serial survives ack", int'(irq_req), 1);
    chk("R1 serial vector again", int'(irq_vec), 8'h23);
    ser_req = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_chain();
    ser_req = 1'b1;
    tmr_ovf = 2'b11;
    wait_clk(1);
    tmr_ovf = 2'b00;
    chk("R2 timer0 first", int'(irq_vec), 8'h0B);
    do_ack();
    do_reti();
    chk("R2 timer1 second", int'(irq_vec), 8'h1B);
    do_ack();
    do_reti();
    chk("R2 serial last", int'(irq_vec), 8'h23);
    do_ack();
    ser_req = 1'b0;
    do_reti();
    chk("R2 chain drained", int'(irq_req), 0);
  endtask

  task automatic t_levels();
    cfg_hi = 5'b10000;
    ser_req = 1'b1;
    pulse_tmr(0);
    chk("R3 upper serial beats timer0", int'(irq_vec), 8'h23);
    chk("R3 irq_hi set", int'(irq_hi), 1);
    do_ack();
    chk("R7 ack sets busy_hi", int'(busy_hi), 1);
    chk("R4 upper handler blocks all", int'(irq_req), 0);
    do_reti();
    chk("R8 reti clears busy_hi", int'(busy_hi), 0);
    ser_req = 1'b0;
    wait_clk(1);
    chk("R3 timer0 low after serial drops", int'(irq_vec), 8'h0B);
    do_ack();
    ser_req = 1'b1;
    wait_clk(1);
    chk("R4 upper preempts low handler", int'(irq_vec), 8'h23);
    do_ack();
    chk("R4 both levels in service", int'({busy_hi, busy_lo}), 3);
    ser_req = 1'b0;
    do_reti();
    chk("R8 inner reti clears upper only", int'({busy_hi, busy_lo}), 1);
    do_reti();
    chk("R8 outer reti clears lower", int'({busy_hi, busy_lo}), 0);
    cfg_hi = 5'b00000;
    wait_clk(1);
  endtask

  task automatic t_enables();
    cfg_gen = 1'b0;
    pulse_tmr(1);
    chk("R6 master enable off", int'(irq_req), 0);
    cfg_gen = 1'b1;
    wait_clk(1);
    chk("R6 latched request after enable", int'(irq_vec), 8'h1B);
    cfg_en = 5'b10111;
    wait_clk(1);
    chk("R6 source mask", int'(irq_req), 0);
    cfg_en = 5'h1F;
    wait_clk(1);
    do_ack();
    do_reti();
    chk("R6 drained", int'(irq_req), 0);
  endtask

  task automatic t_level_pin();
    int n;
    cfg_edge = 2'b00;
    ext_pin_n[0] = 1'b0;
    n = 0;
    while (!irq_req && n < 30) begin
      wait_clk(1);
      n++;
    end
    chk("R5 level request seen", int'(irq_vec), 8'h03);
    ext_pin_n[0] = 1'b1;
    wait_clk(11);
    chk("R5 held until next sample", int'(irq_req), 1);
    wait_clk(1);
    chk("R5 dropped at next sample", int'(irq_req), 0);
  endtask

  task automatic t_edge_pin();
    cfg_edge = 2'b10;
    ext_pin_n[1] = 1'b0;
    wait_clk(PIN_WAIT);
    chk("R9 falling edge latched", int'(irq_vec), 8'h13);
    do_ack();
    chk("R9 ack clears latch", int'(irq_req), 0);
    do_reti();
    chk("R9 low pin alone no request", int'(irq_req), 0);
    ext_pin_n[1] = 1'b1;
    wait_clk(PIN_WAIT);
    chk("R9 rising edge no request", int'(irq_req), 0);
    ext_pin_n[1] = 1'b0;
    wait_clk(PIN_WAIT);
    ext_pin_n[1] = 1'b1;
    wait_clk(PIN_WAIT);
    chk("R9 latch kept after pin returns high", int'(irq_vec), 8'h13);
    do_ack();
    do_reti();
    cfg_edge = 2'b00;
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    t_reset();
    t_timer_vec();
    t_serial();
    t_chain();
    t_levels();
    t_enables();
    t_level_pin();
    t_edge_pin();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule